// File: doc/BRIEF.md
# DMA Channel Address and Count Register Bank

This block keeps the programmable start address and transfer length for four DMA channels, together with the live position of each channel. Software reaches the registers one byte at a time through an eight-port window on a simple register bus. A single byte-pointer toggle is shared by every port. It decides whether an access touches the low or the high byte of a 16-bit register, and it flips on every channel-register access.

A build-time parameter picks 8-bit or 16-bit transfer mode. In 16-bit mode, port numbers are decoded one bit higher, and the programmed base values are doubled before they become live positions. Reads undo that doubling. The transfer engine reports the number of units moved so far on each channel through a per-channel update strobe. The block turns that count into the current address, counting up or down, and into the remaining count, both of which are available at the ports.

Writing the high byte of either register of a channel restarts that channel. Its live address is reloaded from the base address and its progress count is cleared.

Top module: `dma_chan_regbank`

## Requirements
- R1: The register index is bits [3:0] of `bus_port` shifted right by `WIDE`. Index bits [2:1] name the channel, and index bit 0 picks the address register (0) or the count register (1). Accesses whose index bit 3 is 1 belong to another block: they change no register, leave the byte pointer unchanged and return 0.
- R2: Every read or write of a channel register uses the current byte-pointer value and then inverts it. The byte pointer starts at 0 after reset.
- R3: A write made while the byte pointer is 0 replaces bits [7:0] of the selected base register. A write made while it is 1 replaces bits [15:8].
- R4: A high-byte write, to either register of a channel, sets that channel's live address to the 16-bit base address shifted left by `WIDE` (including a byte written in the same access) and clears its progress count to 0.
- R5: The count view is (base count << `WIDE`) minus the progress count, taken modulo 2^17. It is driven on `remain_o` and returned by count-register reads.
- R6: The address view is the live address plus the progress count, or minus it when the channel's `mode_dec_i` bit is 1, taken modulo 2^17. It is driven on `cur_addr_o` and returned by address-register reads.
- R7: Read data is bits [`WIDE` + 8*pointer +: 8] of the selected 17-bit view.
- R8: `ff_clear` forces the byte pointer to 0 at the next edge, and it wins over a toggle in the same cycle.
- R9: A progress update (`xfer_upd_i` bit with its `xfer_i` slice) is visible one cycle after it is presented. A high-byte write to the same channel in the same cycle wins, and the count becomes 0. Updates to other channels are unaffected by that write.
- R10: After reset, all base, live and progress values are 0. `bus_rdata` is 0 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_port | input | PORT_W | Port number |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the access cycle |
| ff_clear | input | 1 | Byte-pointer clear from the control block |
| mode_dec_i | input | 4 | Per-channel decrement-direction bit |
| xfer_upd_i | input | 4 | Per-channel progress-update strobe |
| xfer_i | input | 68 | Per-channel 17-bit progress counts, channel c at [17c +: 17] |
| cur_addr_o | output | 68 | Per-channel 17-bit address view |
| remain_o | output | 68 | Per-channel 17-bit count view |

## Verification
The hardest situation to reach is a progress update that lands in the same cycle as a high-byte write to that channel. Reaching it takes two steps: first steer the shared byte pointer to 1 with a low-byte write, then raise the update strobe so that it spans exactly the edge of the following bus access. The bench also presents an update on a different channel at that same edge. This shows that the reload restarts only the addressed channel.

A further corner is a progress count larger than the doubled base count, whose negative remainder must wrap modulo 2^17. The bench reaches it by loading a small base count and then presenting a large progress value. The 16-bit instance is driven at ports whose index lies one bit higher, which exercises the doubling on load and the halving on read.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;
  localparam int NCH   = 4;
  localparam int CH_W  = $clog2(NCH);
  localparam int IDX_W = 4;
  localparam int BASE_W = 16;
  localparam int CUR_W  = BASE_W + 1;
  localparam int SHW    = 4;

  // base value scaled into the live address/count domain
  function automatic logic [CUR_W-1:0] scale_base(input logic [BASE_W-1:0] b,
                                                  input bit w16);
    logic [CUR_W-1:0] r;
    r = {1'b0, b};
    if (w16) r = {b, 1'b0};
    return r;
  endfunction

  // address as seen by software and the transfer engine
  function automatic logic [CUR_W-1:0] addr_view(input logic [CUR_W-1:0] cur,
                                                 input logic [CUR_W-1:0] done,
                                                 input logic dec);
    return dec ? (cur - done) : (cur + done);
  endfunction

  // units still to move
  function automatic logic [CUR_W-1:0] remain_view(input logic [BASE_W-1:0] cnt,
                                                   input logic [CUR_W-1:0] done,
                                                   input bit w16);
    return scale_base(cnt, w16) - done;
  endfunction

  // byte lane selected by width shift and byte pointer
  function automatic logic [7:0] pick_byte(input logic [CUR_W-1:0] v,
                                           input bit w16,
                                           input logic ptr);
    logic [SHW-1:0] sh;
    logic [CUR_W+7:0] ext;
    sh  = SHW'(w16) + (ptr ? SHW'(8) : SHW'(0));
    ext = {8'h00, v} >> sh;
    return ext[7:0];
  endfunction
endpackage

// File: rtl/dma_rb_decode.sv
module dma_rb_decode
  import dma_rb_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter bit WIDE   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [PORT_W-1:0] bus_port,
  input  logic              ff_clear,
  output logic              ff_q,
  output logic              chan_acc,
  output logic [CH_W-1:0]   ch_sel,
  output logic              is_cnt,
  output logic [NCH-1:0]    lo_wr,
  output logic [NCH-1:0]    hi_wr
);
  logic [IDX_W-1:0] idx;

  assign idx      = IDX_W'(bus_port >> WIDE);
  assign chan_acc = bus_sel && !idx[IDX_W-1];
  assign ch_sel   = idx[CH_W:1];
  assign is_cnt   = idx[0];

  always_ff @(posedge clk) begin
    if (!rst_n)        ff_q <= 1'b0;
    else if (ff_clear) ff_q <= 1'b0;
    else if (chan_acc) ff_q <= !ff_q;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_wr
    logic hit;
    assign hit      = chan_acc && bus_wr && (ch_sel == CH_W'(c));
    assign lo_wr[c] = hit && !ff_q;
    assign hi_wr[c] = hit && ff_q;
  end
endmodule

// File: rtl/dma_rb_channel.sv
module dma_rb_channel
  import dma_rb_pkg::*;
#(
  parameter bit WIDE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_wr,
  input  logic              hi_wr,
  input  logic              is_cnt,
  input  logic [7:0]        wdata,
  input  logic              upd,
  input  logic [CUR_W-1:0]  upd_val,
  input  logic              dec,
  output logic [BASE_W-1:0] base_addr,
  output logic [BASE_W-1:0] base_cnt,
  output logic [CUR_W-1:0]  done_q,
  output logic [CUR_W-1:0]  addr_v,
  output logic [CUR_W-1:0]  rem_v
);
  logic [CUR_W-1:0]  cur_q;
  logic [BASE_W-1:0] addr_after;

  // address base as it stands after this access
  assign addr_after = is_cnt ? base_addr : {wdata, base_addr[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_q     <= '0;
      done_q    <= '0;
    end else begin
      if (lo_wr) begin
        if (is_cnt) base_cnt[7:0]  <= wdata;
        else        base_addr[7:0] <= wdata;
      end
      if (hi_wr) begin
        if (is_cnt) base_cnt[15:8]  <= wdata;
        else        base_addr[15:8] <= wdata;
        cur_q  <= scale_base(addr_after, WIDE);
        done_q <= '0;
      end else if (upd) begin
        done_q <= upd_val;
      end
    end
  end

  assign addr_v = addr_view(cur_q, done_q, dec);
  assign rem_v  = remain_view(base_cnt, done_q, WIDE);
endmodule

// File: rtl/dma_rb_readmux.sv
module dma_rb_readmux
  import dma_rb_pkg::*;
#(
  parameter bit WIDE = 1'b0
) (
  input  logic             rd_en,
  input  logic             ptr,
  input  logic [CH_W-1:0]  ch_sel,
  input  logic             is_cnt,
  input  logic [CUR_W-1:0] addr_v [NCH],
  input  logic [CUR_W-1:0] rem_v  [NCH],
  output logic [7:0]       rdata
);
  logic [CUR_W-1:0] sel_v;

  always_comb begin
    sel_v = is_cnt ? rem_v[ch_sel] : addr_v[ch_sel];
    rdata = rd_en ? pick_byte(sel_v, WIDE, ptr) : 8'h00;
  end
endmodule

// File: rtl/dma_chan_regbank.sv
module dma_chan_regbank
  import dma_rb_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter bit WIDE   = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [PORT_W-1:0]    bus_port,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  input  logic                 ff_clear,
  input  logic [NCH-1:0]       mode_dec_i,
  input  logic [NCH-1:0]       xfer_upd_i,
  input  logic [NCH*CUR_W-1:0] xfer_i,
  output logic [NCH*CUR_W-1:0] cur_addr_o,
  output logic [NCH*CUR_W-1:0] remain_o
);
  // named events and state brought out for the checker
  logic                  ff_q;
  logic                  chan_acc;
  logic [CH_W-1:0]       ch_sel;
  logic                  is_cnt;
  logic [NCH-1:0]        lo_wr;
  logic [NCH-1:0]        hi_wr;
  logic [NCH*BASE_W-1:0] base_addr_flat;
  logic [NCH*BASE_W-1:0] base_cnt_flat;
  logic [NCH*CUR_W-1:0]  xfer_flat;
  logic [CUR_W-1:0]      addr_v [NCH];
  logic [CUR_W-1:0]      rem_v  [NCH];

  dma_rb_decode #(.PORT_W(PORT_W), .WIDE(WIDE)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_port (bus_port),
    .ff_clear (ff_clear),
    .ff_q     (ff_q),
    .chan_acc (chan_acc),
    .ch_sel   (ch_sel),
    .is_cnt   (is_cnt),
    .lo_wr    (lo_wr),
    .hi_wr    (hi_wr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_rb_channel #(.WIDE(WIDE)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .lo_wr     (lo_wr[c]),
      .hi_wr     (hi_wr[c]),
      .is_cnt    (is_cnt),
      .wdata     (bus_wdata),
      .upd       (xfer_upd_i[c]),
      .upd_val   (xfer_i[c*CUR_W +: CUR_W]),
      .dec       (mode_dec_i[c]),
      .base_addr (base_addr_flat[c*BASE_W +: BASE_W]),
      .base_cnt  (base_cnt_flat[c*BASE_W +: BASE_W]),
      .done_q    (xfer_flat[c*CUR_W +: CUR_W]),
      .addr_v    (addr_v[c]),
      .rem_v     (rem_v[c])
    );
    assign cur_addr_o[c*CUR_W +: CUR_W] = addr_v[c];
    assign remain_o[c*CUR_W +: CUR_W]   = rem_v[c];
  end

  dma_rb_readmux #(.WIDE(WIDE)) u_rmux (
    .rd_en  (chan_acc && !bus_wr),
    .ptr    (ff_q),
    .ch_sel (ch_sel),
    .is_cnt (is_cnt),
    .addr_v (addr_v),
    .rem_v  (rem_v),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/dma_chan_regbank_chk.sv
module dma_chan_regbank_chk
  import dma_rb_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter bit WIDE   = 1'b0
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_sel,
  input logic                  bus_wr,
  input logic [PORT_W-1:0]     bus_port,
  input logic [7:0]            bus_rdata,
  input logic                  ff_clear,
  input logic                  ff_q,
  input logic                  chan_acc,
  input logic [NCH-1:0]        lo_wr,
  input logic [NCH-1:0]        hi_wr,
  input logic [NCH-1:0]        xfer_upd_i,
  input logic [NCH*CUR_W-1:0]  xfer_i,
  input logic [NCH*CUR_W-1:0]  xfer_flat,
  input logic [NCH*BASE_W-1:0] base_addr_flat,
  input logic [NCH*BASE_W-1:0] base_cnt_flat,
  input logic [NCH*CUR_W-1:0]  cur_addr_o
);
  logic [IDX_W-1:0] pidx;
  assign pidx = IDX_W'(bus_port >> WIDE);

  AST_FOREIGN_PORT_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && pidx[IDX_W-1] && !ff_clear) |=> $stable(ff_q)); // R1

  AST_PTR_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_acc && !ff_clear) |=> (ff_q != $past(ff_q))); // R2

  AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ff_clear |=> !ff_q); // R8

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |-> (bus_rdata == 8'h00)); // R10

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_LOW_WRITE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      lo_wr[c] |=> ($stable(base_addr_flat[c*BASE_W+8 +: 8]) &&
                    $stable(base_cnt_flat[c*BASE_W+8 +: 8]))); // R3

    AST_HIGH_WRITE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      hi_wr[c] |=> ((xfer_flat[c*CUR_W +: CUR_W] == '0) &&
                    (cur_addr_o[c*CUR_W +: CUR_W] ==
                     scale_base(base_addr_flat[c*BASE_W +: BASE_W], WIDE)))); // R4

    AST_UPDATE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_upd_i[c] && !hi_wr[c]) |=>
        (xfer_flat[c*CUR_W +: CUR_W] == $past(xfer_i[c*CUR_W +: CUR_W]))); // R9
  end
endmodule

bind dma_chan_regbank dma_chan_regbank_chk #(.PORT_W(PORT_W), .WIDE(WIDE)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_sel        (bus_sel),
  .bus_wr         (bus_wr),
  .bus_port       (bus_port),
  .bus_rdata      (bus_rdata),
  .ff_clear       (ff_clear),
  .ff_q           (ff_q),
  .chan_acc       (chan_acc),
  .lo_wr          (lo_wr),
  .hi_wr          (hi_wr),
  .xfer_upd_i     (xfer_upd_i),
  .xfer_i         (xfer_i),
  .xfer_flat      (xfer_flat),
  .base_addr_flat (base_addr_flat),
  .base_cnt_flat  (base_cnt_flat),
  .cur_addr_o     (cur_addr_o)
);

// File: tb/dma_chan_regbank_bench.sv
`timescale 1ns/1ps
module dma_chan_regbank_bench;
  localparam int NC = 4;
  localparam int CW = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // 8-bit instance signals
  logic            s1_sel = 0, s1_wr = 0, s1_clr = 0;
  logic [7:0]      s1_port = 0, s1_wd = 0, s1_rd;
  logic [NC-1:0]   s1_dec = 0, s1_upd = 0;
  logic [NC*CW-1:0] s1_x = 0, s1_cur, s1_rem;
  // 16-bit instance signals
  logic            s2_sel = 0, s2_wr = 0;
  logic [7:0]      s2_port = 0, s2_wd = 0, s2_rd;
  logic [NC-1:0]   s2_upd = 0;
  logic [NC*CW-1:0] s2_x = 0, s2_cur, s2_rem;

  dma_chan_regbank #(.PORT_W(8), .WIDE(1'b0)) u_dma_chan_regbank (
    .clk(clk), .rst_n(rst_n), .bus_sel(s1_sel), .bus_wr(s1_wr), .bus_port(s1_port),
    .bus_wdata(s1_wd), .bus_rdata(s1_rd), .ff_clear(s1_clr), .mode_dec_i(s1_dec),
    .xfer_upd_i(s1_upd), .xfer_i(s1_x), .cur_addr_o(s1_cur), .remain_o(s1_rem));

  dma_chan_regbank #(.PORT_W(8), .WIDE(1'b1)) u_dma_chan_regbank_w16 (
    .clk(clk), .rst_n(rst_n), .bus_sel(s2_sel), .bus_wr(s2_wr), .bus_port(s2_port),
    .bus_wdata(s2_wd), .bus_rdata(s2_rd), .ff_clear(1'b0), .mode_dec_i(4'b0000),
    .xfer_upd_i(s2_upd), .xfer_i(s2_x), .cur_addr_o(s2_cur), .remain_o(s2_rem));

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one bus access; read data sampled mid-cycle before the edge
  task automatic acc(input bit w16, input bit wr, input logic [7:0] port,
                     input logic [7:0] d, output logic [7:0] rd);
    @(negedge clk);
    if (w16) begin s2_sel = 1; s2_wr = wr; s2_port = port; s2_wd = d; end
    else     begin s1_sel = 1; s1_wr = wr; s1_port = port; s1_wd = d; end
    #1 rd = w16 ? s2_rd : s1_rd;
    @(posedge clk); #1;
    s1_sel = 0; s1_wr = 0; s2_sel = 0; s2_wr = 0;
  endtask

  function automatic logic [CW-1:0] sl(input logic [NC*CW-1:0] v, input int c);
    return v[c*CW +: CW];
  endfunction

  // {write, port, wdata, expected read byte}
  localparam logic [24:0] VEC [16] = '{
    {1'b1, 8'h00, 8'h34, 8'h00}, {1'b1, 8'h00, 8'h12, 8'h00},
    {1'b0, 8'h00, 8'h00, 8'h34}, {1'b0, 8'h00, 8'h00, 8'h12},
    {1'b1, 8'h03, 8'hFF, 8'h00}, {1'b1, 8'h03, 8'h00, 8'h00},
    {1'b0, 8'h03, 8'h00, 8'hFF}, {1'b0, 8'h03, 8'h00, 8'h00},
    {1'b1, 8'h06, 8'h00, 8'h00}, {1'b1, 8'h06, 8'h80, 8'h00},
    {1'b0, 8'h06, 8'h00, 8'h00}, {1'b0, 8'h06, 8'h00, 8'h80},
    {1'b0, 8'h08, 8'h00, 8'h00}, {1'b1, 8'h0B, 8'h99, 8'h00},
    {1'b0, 8'h00, 8'h00, 8'h34}, {1'b0, 8'h00, 8'h00, 8'h12}
  };

  initial begin : watchdog
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R10 reset state
    chk("R10 cur_addr after reset", 32'(s1_cur), 0);
    chk("R10 remain after reset", 32'(s1_rem), 0);
    chk("R10 idle rdata", 32'(s1_rd), 0);

    // table: R1 decode, R2 pointer, R3 byte lanes, R7 byte pick
    for (int i = 0; i < 16; i++) begin
      acc(0, VEC[i][24], VEC[i][23:16], VEC[i][15:8], rd);
      if (!VEC[i][24])
        chk(VEC[i][19] ? "R1 foreign port read" : "R7 table read", 32'(rd), 32'(VEC[i][7:0]));
    end
    chk("R4 ch0 live address after high write", 32'(sl(s1_cur, 0)), 32'h1234);
    chk("R4 ch3 live address", 32'(sl(s1_cur, 3)), 32'h8000);

    // R6 increment then decrement view, update visible next cycle (R9)
    @(negedge clk); s1_upd = 4'b0001; s1_x[0 +: CW] = 17'h10;
    @(posedge clk); #1 s1_upd = 0;
    chk("R9 update visible next cycle", 32'(sl(s1_cur, 0)), 32'h1244);
    s1_dec[0] = 1'b1; #1;
    chk("R6 decrement view", 32'(sl(s1_cur, 0)), 32'h1224);
    acc(0, 0, 8'h00, 8'h00, rd); chk("R6 read low byte decrement", 32'(rd), 32'h24);
    acc(0, 0, 8'h00, 8'h00, rd); chk("R7 read high byte", 32'(rd), 32'h12);

    // R5 remainder wraps below zero
    @(negedge clk); s1_upd = 4'b0010; s1_x[CW +: CW] = 17'h100;
    @(posedge clk); #1 s1_upd = 0;
    chk("R5 remain wraps", 32'(sl(s1_rem, 1)), 32'h1FFFF);
    acc(0, 0, 8'h03, 8'h00, rd); chk("R5 read count low", 32'(rd), 32'hFF);
    acc(0, 0, 8'h03, 8'h00, rd); chk("R5 read count high", 32'(rd), 32'hFF);

    // R8 clear pointer mid-pair, also collides with an access (clear wins)
    acc(0, 1, 8'h02, 8'h11, rd);
    @(negedge clk); s1_clr = 1; @(posedge clk); #1 s1_clr = 0;
    acc(0, 1, 8'h02, 8'h22, rd);
    acc(0, 1, 8'h02, 8'h33, rd);
    chk("R8 pointer cleared, ch1 address", 32'(sl(s1_cur, 1)), 32'h3322);
    chk("R4 ch1 progress cleared by high write", 32'(sl(s1_rem, 1)), 32'hFF);
    @(negedge clk); s1_clr = 1; s1_sel = 1; s1_port = 8'h02;
    @(posedge clk); #1 s1_clr = 0; s1_sel = 0;
    acc(0, 0, 8'h02, 8'h00, rd); chk("R8 clear beats toggle", 32'(rd), 32'h22);
    acc(0, 0, 8'h02, 8'h00, rd);

    // R9 collision: update and high write on ch0 at one edge, ch2 update too
    s1_dec[0] = 1'b0;
    acc(0, 1, 8'h00, 8'h78, rd);
    s1_upd = 4'b0101; s1_x[0 +: CW] = 17'h55; s1_x[2*CW +: CW] = 17'h7;
    acc(0, 1, 8'h00, 8'h56, rd);
    s1_upd = 0;
    chk("R9 high write wins over update", 32'(sl(s1_cur, 0)), 32'h5678);
    chk("R9 ch0 progress zero", 32'(sl(s1_rem, 0)), 32'h0);
    chk("R9 other channel update kept", 32'(sl(s1_rem, 2)), 32'h1FFF9);

    // 16-bit instance: R1 shifted decode, R4 doubling, R7 halving
    acc(1, 1, 8'h04, 8'h34, rd);
    acc(1, 1, 8'h05, 8'h12, rd);
    chk("R4 w16 live address doubled", 32'(sl(s2_cur, 1)), 32'h2468);
    @(negedge clk); s2_upd = 4'b0010; s2_x[CW +: CW] = 17'h2;
    @(posedge clk); #1 s2_upd = 0;
    acc(1, 0, 8'h04, 8'h00, rd); chk("R7 w16 read low", 32'(rd), 32'h35);
    acc(1, 0, 8'h04, 8'h00, rd); chk("R7 w16 read high", 32'(rd), 32'h12);
    acc(1, 1, 8'h02, 8'hFF, rd);
    acc(1, 1, 8'h02, 8'hFF, rd);
    chk("R5 w16 remain 17 bits", 32'(sl(s2_rem, 0)), 32'h1FFFE);
    acc(1, 0, 8'h10, 8'h00, rd); chk("R1 w16 foreign port", 32'(rd), 32'h0);
    acc(1, 0, 8'h02, 8'h00, rd); chk("R2 w16 pointer unchanged", 32'(rd), 32'hFF);
    acc(1, 0, 8'h02, 8'h00, rd);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule